// File: doc/BRIEF.md
# Signed/Unsigned Truncating Multiplier

This block multiplies two register operands that are either 8 or 16 bits wide. It can treat them as unsigned or as two's complement signed values. Inside, it forms the complete double-width product. It hands back only the low half, at the selected operand width. The high half is discarded, but it is first inspected to decide whether the truncated result lost information.

That decision drives both the overflow and carry flag outputs, which always agree with each other. The sign and zero flags are not defined by a multiply, so the block returns the values it received with the request unchanged. A caller can therefore merge the flag outputs straight back into its status state.

Each request is a one-cycle `start` pulse. The answer appears two clock cycles later, marked by a single-cycle `done` pulse. A new request may be issued on every cycle.

Top module: `trunc_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done`, `product`, `of_out`, `cf_out`, `sf_out` and `zf_out` are all 0.
- R2: A `start` sampled high at a rising edge produces exactly one `done` pulse, two rising edges later. Starts on consecutive cycles produce consecutive `done` pulses, in the same order.
- R3: When `done` is high, `product` holds the low N bits of the operand product, where N is 8 when `wide_sel`=0 and 16 when `wide_sel`=1. These low bits are identical in signed mode (`signed_mode`=1) and unsigned mode (`signed_mode`=0).
- R4: With `wide_sel`=0, only bits 7:0 of `opa` and `opb` are used, and `product[15:8]` is 0 when `done` is high. Bits 15:8 of the operands have no effect on any output.
- R5: In unsigned mode, `of_out` and `cf_out` are 1 exactly when the upper N bits of the 2N-bit product contain a 1. Example: 8-bit 0xFD×0xFB gives 0xF80F, so the low byte is 0x0F and the flags are 1.
- R6: In signed mode, `of_out` and `cf_out` are 1 exactly when the 2N-bit product differs from the N-bit result sign-extended to 2N bits. Examples: 8-bit 0xFD×0xFB gives 0x0F with the flags at 0; 16-bit 0xFFFC×0xFFFD gives 0x000C with the flags at 0, while the same operands in unsigned mode set the flags.
- R7: When `done` is high, `of_out` equals `cf_out`. `sf_out` and `zf_out` equal the `sf_in` and `zf_in` values that were sampled together with the matching `start`.
- R8: While `done` is low, `product` and all four flag outputs hold the values of the last completed multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; operands and control are sampled with it |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| wide_sel | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| sf_in | input | 1 | Sign flag value before the multiply |
| zf_in | input | 1 | Zero flag value before the multiply |
| done | output | 1 | One-cycle pulse marking a valid result |
| product | output | 16 | Truncated product, zero-extended in 8-bit mode |
| of_out | output | 1 | Overflow flag after the multiply |
| cf_out | output | 1 | Carry flag after the multiply, always equal to `of_out` |
| sf_out | output | 1 | Sign flag after the multiply, carried through unchanged |
| zf_out | output | 1 | Zero flag after the multiply, carried through unchanged |

## Verification
The bench builds the block with its defaults: a 16-bit wide width and an 8-bit narrow width. With those values it can drive both operand sizes from one instance. It can therefore compare the narrow-width flag decision, which looks at bits 15:7 of the product, against the wide-width decision, which looks at bits 31:15, using the same operand bit patterns. The small widths also make the boundary operands easy to reach directly: the most negative value, all ones, and products that land just inside or just outside the signed range.

// File: rtl/trunc_mul_pkg.sv
package trunc_mul_pkg;

    typedef enum logic {
        MODE_UNS = 1'b0,
        MODE_SGN = 1'b1
    } mul_mode_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic cry;
    } flag_t;

    localparam flag_t FLAGS_CLEAR = '{ovf: 1'b0, sgn: 1'b0, zro: 1'b0, cry: 1'b0};

endpackage

// File: rtl/trunc_mul_prep.sv
module trunc_mul_prep
    import trunc_mul_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  mul_mode_e             mode,
    input  logic                  wide,
    input  logic [WIDE_W-1:0]     op,
    output logic [2*WIDE_W-1:0]   ext
);
    localparam int EXT_W = 2 * WIDE_W;

    logic sign_w;
    logic sign_n;

    always_comb begin
        sign_w = (mode == MODE_SGN) && op[WIDE_W-1];
        sign_n = (mode == MODE_SGN) && op[NARROW_W-1];
        if (wide) begin
            ext = {{WIDE_W{sign_w}}, op};
        end else begin
            ext = {{(EXT_W-NARROW_W){sign_n}}, op[NARROW_W-1:0]};
        end
    end

endmodule

// File: rtl/trunc_mul_core.sv
module trunc_mul_core
    import trunc_mul_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  mul_mode_e             mode,
    input  logic                  wide,
    input  logic [2*WIDE_W-1:0]   ext_a,
    input  logic [2*WIDE_W-1:0]   ext_b,
    output logic [WIDE_W-1:0]     low,
    output logic                  ovf
);
    localparam int EXT_W = 2 * WIDE_W;
    localparam int NX_W  = 2 * NARROW_W;

    logic [EXT_W-1:0]    full;
    logic [WIDE_W:0]     top_w;
    logic [NARROW_W:0]   top_n;

    always_comb begin
        full  = ext_a * ext_b;
        top_w = full[EXT_W-1:WIDE_W-1];
        top_n = full[NX_W-1:NARROW_W-1];
        if (wide) begin
            low = full[WIDE_W-1:0];
            if (mode == MODE_SGN) begin
                ovf = !((top_w == '0) || (top_w == '1));
            end else begin
                ovf = |top_w[WIDE_W:1];
            end
        end else begin
            low = {{(WIDE_W-NARROW_W){1'b0}}, full[NARROW_W-1:0]};
            if (mode == MODE_SGN) begin
                ovf = !((top_n == '0) || (top_n == '1));
            end else begin
                ovf = |top_n[NARROW_W:1];
            end
        end
    end

endmodule

// File: rtl/trunc_mul.sv
module trunc_mul
    import trunc_mul_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              signed_mode,
    input  logic              wide_sel,
    input  logic [WIDE_W-1:0] opa,
    input  logic [WIDE_W-1:0] opb,
    input  logic              sf_in,
    input  logic              zf_in,
    output logic              done,
    output logic [WIDE_W-1:0] product,
    output logic              of_out,
    output logic              cf_out,
    output logic              sf_out,
    output logic              zf_out
);
    localparam int EXT_W  = 2 * WIDE_W;
    localparam int N_OPS  = 2;

    mul_mode_e                    mode_in;
    logic [N_OPS-1:0][WIDE_W-1:0] ops;
    logic [N_OPS-1:0][EXT_W-1:0]  ext;

    assign mode_in = signed_mode ? MODE_SGN : MODE_UNS;
    assign ops[0]  = opa;
    assign ops[1]  = opb;

    generate
        for (genvar gi = 0; gi < N_OPS; gi++) begin : g_prep
            trunc_mul_prep #(
                .WIDE_W   (WIDE_W),
                .NARROW_W (NARROW_W)
            ) u_prep (
                .mode (mode_in),
                .wide (wide_sel),
                .op   (ops[gi]),
                .ext  (ext[gi])
            );
        end
    endgenerate

    // Stage 1: conditioned operands and carried flags
    logic             s1_vld;
    mul_mode_e        s1_mode;
    logic             s1_wide;
    logic [EXT_W-1:0] s1_a;
    logic [EXT_W-1:0] s1_b;
    logic             s1_sf;
    logic             s1_zf;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_mode <= MODE_UNS;
            s1_wide <= 1'b0;
            s1_a    <= '0;
            s1_b    <= '0;
            s1_sf   <= 1'b0;
            s1_zf   <= 1'b0;
        end else begin
            s1_vld <= start;
            if (start) begin
                s1_mode <= mode_in;
                s1_wide <= wide_sel;
                s1_a    <= ext[0];
                s1_b    <= ext[1];
                s1_sf   <= sf_in;
                s1_zf   <= zf_in;
            end
        end
    end

    logic [WIDE_W-1:0] core_low;
    logic              core_ovf;

    trunc_mul_core #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_core (
        .mode  (s1_mode),
        .wide  (s1_wide),
        .ext_a (s1_a),
        .ext_b (s1_b),
        .low   (core_low),
        .ovf   (core_ovf)
    );

    // Stage 2: result registers
    logic              done_q;
    logic [WIDE_W-1:0] prod_q;
    flag_t             flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            prod_q <= '0;
            flg_q  <= FLAGS_CLEAR;
        end else begin
            done_q <= s1_vld;
            if (s1_vld) begin
                prod_q <= core_low;
                flg_q  <= '{ovf: core_ovf, sgn: s1_sf, zro: s1_zf, cry: core_ovf};
            end
        end
    end

    assign done    = done_q;
    assign product = prod_q;
    assign of_out  = flg_q.ovf;
    assign cf_out  = flg_q.cry;
    assign sf_out  = flg_q.sgn;
    assign zf_out  = flg_q.zro;

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start |-> ##2 done);  // R2
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 2));  // R2
    AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(wide_sel, 2)) |-> (product[WIDE_W-1:NARROW_W] == '0));  // R4
    AST_OF_CF_AGREE: assert property (@(posedge clk) disable iff (rst)
        done |-> (of_out == cf_out));  // R7
    AST_SZ_CARRIED: assert property (@(posedge clk) disable iff (rst)
        done |-> ({sf_out, zf_out} == $past({sf_in, zf_in}, 2)));  // R7
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(product) && $stable({of_out, cf_out, sf_out, zf_out})));  // R8

endmodule

// File: tb/trunc_mul_test.sv
module trunc_mul_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic        wide_sel = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        sf_in = 1'b0;
    logic        zf_in = 1'b0;
    logic        done;
    logic [15:0] product;
    logic        of_out, cf_out, sf_out, zf_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    trunc_mul uut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .wide_sel(wide_sel), .opa(opa), .opb(opb), .sf_in(sf_in), .zf_in(zf_in),
        .done(done), .product(product), .of_out(of_out), .cf_out(cf_out),
        .sf_out(sf_out), .zf_out(zf_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic void model(input bit s, input bit w, input logic [15:0] a,
                                  input logic [15:0] b, output logic [15:0] low,
                                  output bit ov);
        int     n = w ? 16 : 8;
        longint mask = (longint'(1) << n) - 1;
        longint va = longint'(a) & mask;
        longint vb = longint'(b) & mask;
        longint full, lo, lo_s;
        if (s && va[n-1]) va = va - (longint'(1) << n);
        if (s && vb[n-1]) vb = vb - (longint'(1) << n);
        full = va * vb;
        lo   = full & mask;
        low  = lo[15:0];
        if (s) begin
            lo_s = lo[n-1] ? lo - (longint'(1) << n) : lo;
            ov = (full != lo_s);
        end else begin
            ov = ((full >> n) != 0);
        end
    endfunction

    task automatic check_out(input bit s, input bit w, input logic [15:0] a,
                             input logic [15:0] b, input bit sf, input bit zf);
        logic [15:0] el;
        bit          eo;
        model(s, w, a, b, el, eo);
        chk(done === 1'b1, "R2 done", longint'(done), 1);
        chk(product === el, w ? "R3 product" : "R4 product", longint'(product), longint'(el));
        chk(of_out === eo, s ? "R6 of" : "R5 of", longint'(of_out), longint'(eo));
        chk(cf_out === eo, s ? "R6 cf" : "R5 cf", longint'(cf_out), longint'(eo));
        chk({sf_out, zf_out} === {sf, zf}, "R7 sf/zf", longint'({sf_out, zf_out}),
            longint'({sf, zf}));
    endtask

    task automatic one_mul(input bit s, input bit w, input logic [15:0] a,
                           input logic [15:0] b, input bit sf, input bit zf);
        logic [15:0] held;
        @(negedge clk);
        start = 1'b1; signed_mode = s; wide_sel = w; opa = a; opb = b;
        sf_in = sf; zf_in = zf;
        @(negedge clk);
        start = 1'b0; opa = ~a; opb = ~b; sf_in = ~sf; zf_in = ~zf;
        signed_mode = ~s;
        chk(done === 1'b0, "R2 early", longint'(done), 0);
        @(negedge clk);
        check_out(s, w, a, b, sf, zf);
        held = product;
        @(negedge clk);
        chk(done === 1'b0, "R2 single pulse", longint'(done), 0);
        chk(product === held, "R8 hold", longint'(product), longint'(held));
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(done === 1'b0, "R1 done", longint'(done), 0);
        chk(product === 16'h0, "R1 product", longint'(product), 0);
        chk({of_out, cf_out, sf_out, zf_out} === 4'h0, "R1 flags",
            longint'({of_out, cf_out, sf_out, zf_out}), 0);
    endtask

    task automatic test_examples();
        one_mul(1'b0, 1'b0, 16'h00FD, 16'h00FB, 1'b0, 1'b0); // R5 sets flags
        one_mul(1'b1, 1'b0, 16'h00FD, 16'h00FB, 1'b1, 1'b0); // R6 clear
        one_mul(1'b1, 1'b1, 16'hFFFC, 16'hFFFD, 1'b0, 1'b1); // R6 wide clear
        one_mul(1'b0, 1'b1, 16'hFFFC, 16'hFFFD, 1'b1, 1'b1); // R5 wide set
    endtask

    task automatic test_narrow_ignore();
        one_mul(1'b0, 1'b0, 16'hAB05, 16'h3C03, 1'b0, 1'b0); // R4
        one_mul(1'b1, 1'b0, 16'h7FFD, 16'h80FB, 1'b1, 1'b1); // R4
    endtask

    task automatic test_boundaries();
        one_mul(1'b1, 1'b0, 16'h0080, 16'h0080, 1'b0, 1'b0); // R6 -128*-128
        one_mul(1'b1, 1'b0, 16'h0080, 16'h0001, 1'b0, 1'b0); // R6 fits
        one_mul(1'b1, 1'b0, 16'h0080, 16'h00FF, 1'b0, 1'b0); // R6 +128 out
        one_mul(1'b1, 1'b1, 16'h8000, 16'hFFFF, 1'b1, 1'b0); // R6 wide
        one_mul(1'b1, 1'b1, 16'h00B5, 16'h00B5, 1'b0, 1'b1); // R6 near edge
        one_mul(1'b0, 1'b1, 16'hFFFF, 16'h0001, 1'b0, 1'b0); // R5 clear
        one_mul(1'b0, 1'b1, 16'h0100, 16'h0100, 1'b0, 1'b0); // R5 exact carry
        one_mul(1'b0, 1'b0, 16'h0010, 16'h0010, 1'b0, 1'b0); // R5 narrow carry
        one_mul(1'b0, 1'b0, 16'h000F, 16'h0011, 1'b0, 1'b0); // R5 0xFF no carry
    endtask

    task automatic test_mode_same_low();
        logic [15:0] lo_u, lo_s;
        one_mul(1'b0, 1'b1, 16'hC3A5, 16'h9E17, 1'b0, 1'b0);
        lo_u = product;
        one_mul(1'b1, 1'b1, 16'hC3A5, 16'h9E17, 1'b0, 1'b0);
        lo_s = product;
        chk(lo_u === lo_s, "R3 modes agree", longint'(lo_s), longint'(lo_u));
    endtask

    task automatic test_sweep();
        logic [15:0] a = 16'h1D3B;
        logic [15:0] b = 16'h82F1;
        for (int i = 0; i < 24; i++) begin
            a = {a[14:0], a[15] ^ a[13] ^ a[12] ^ a[10]};
            b = {b[14:0], b[15] ^ b[13] ^ b[12] ^ b[10]};
            one_mul(i[0], i[1], a, b, i[2], i[3]); // R3 R5 R6
        end
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        start = 1'b1; signed_mode = 1'b1; wide_sel = 1'b0; opa = 16'h00FD; opb = 16'h00FB;
        sf_in = 1'b1; zf_in = 1'b0;
        @(negedge clk);
        signed_mode = 1'b0; wide_sel = 1'b1; opa = 16'hFFFC; opb = 16'hFFFD;
        sf_in = 1'b0; zf_in = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_out(1'b1, 1'b0, 16'h00FD, 16'h00FB, 1'b1, 1'b0); // R2 first
        @(negedge clk);
        check_out(1'b0, 1'b1, 16'hFFFC, 16'hFFFD, 1'b0, 1'b1); // R2 second
        @(negedge clk);
        chk(done === 1'b0, "R2 pulse count", longint'(done), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        test_reset();                // R1 during reset
        rst = 1'b0;
        test_reset();                // R1 after release
        test_examples();
        test_narrow_ignore();
        test_boundaries();
        test_mode_same_low();
        test_sweep();
        test_back_to_back();
        summary();
    end

endmodule